// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single line. It samples the line at sixteen times the bit rate, marked by a one-cycle `tick` strobe. It looks for a start bit and assembles 5 to 8 data bits, least significant first, with optional even or odd parity. Each completed character goes into an eight-entry receive queue together with its own error flags. Sticky status bits collect parity, framing, overrun and break events until software clears them.

A break is a character time in which the data bits, the parity bit and the stop bit are all zero. A break loads exactly one queue entry, marked as a break. After that the receiver loads nothing until the line has been high for half a bit time. A separate break-change flag is raised when a break is recognised and again when it ends. Only its own clear command lowers it.

Software controls the receiver with single-cycle command pulses: enable, disable, receiver reset, clear error status and clear break change. It reads the queue through a valid/pop pair at the head.

Top module: `brk_uart_rx`

## Requirements
- R1: After `rst`, the receiver is off (`rx_active`=0), the queue is empty (`rd_valid`=0), and all status bits and `brk_chg` are 0.
- R2: When enabled, a frame (start low, data bits least significant first, optional parity, stop high) puts one entry into the queue. Entries leave in arrival order, one on each cycle in which `rd_pop` is high while `rd_valid` is 1.
- R3: `cfg_len` code c selects 5+c data bits (0 gives 5, 3 gives 8), with the data right-aligned in `rd_data` and the upper bits 0. With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity (data plus parity bit hold an even number of ones) and 1 selects odd parity.
- R4: A parity mismatch sets `rd_pe` on that entry and sets sticky `sts_pe`.
- R5: A stop bit sampled low on a character that is not all zero sets `rd_fe` on that entry and sets sticky `sts_fe`.
- R6: A character whose data bits and parity bit are all zero and whose stop bit is low is a break. It loads one entry with `rd_brk`=1, `rd_data`=0, `rd_fe`=0 and `rd_pe`=0, and sets `sts_brk`. No further entry is loaded until the line has been high for 8 consecutive ticks.
- R7: `brk_chg` is set when a break is recognised and again when its end is recognised (8 consecutive high ticks). Only `cmd_clr_brk_chg` clears it; `cmd_clr_err` and `cmd_rx_reset` leave it unchanged. A high pulse shorter than 8 ticks does not end a break.
- R8: `cmd_clr_err` clears `sts_brk`, `sts_fe`, `sts_pe` and `sts_ovr` together. A clear wins over an event in the same cycle.
- R9: A character that completes while the queue holds 8 entries sets sticky `sts_ovr` and is dropped. The 8 stored entries are kept unchanged.
- R10: `cmd_rx_dis` stops the receiver at once. A character being assembled is lost, and the status bits keep their values. `cmd_rx_en` puts the receiver into the start-bit search from any state.
- R11: `cmd_rx_reset` turns the receiver off, empties the queue and clears `sts_brk`, `sts_fe`, `sts_pe` and `sts_ovr`.
- R12: A low level that is no longer low when sampled at mid start bit is a false start. It loads nothing, and the receiver returns to the search.
- R13: If the line drops low partway through a character and stays low, that character is loaded with `rd_fe`=1. The next character time is then recognised as a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial input line, high when idle |
| cfg_len | input | 2 | Data length code, 5+code bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cmd_rx_en | input | 1 | Enable pulse |
| cmd_rx_dis | input | 1 | Disable pulse |
| cmd_rx_reset | input | 1 | Receiver reset pulse |
| cmd_clr_err | input | 1 | Clear error status pulse |
| cmd_clr_brk_chg | input | 1 | Clear break-change flag pulse |
| rd_pop | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head entry data |
| rd_brk | output | 1 | Head entry is a break |
| rd_fe | output | 1 | Head entry framing error |
| rd_pe | output | 1 | Head entry parity error |
| sts_brk | output | 1 | Sticky break received |
| sts_fe | output | 1 | Sticky framing error |
| sts_pe | output | 1 | Sticky parity error |
| sts_ovr | output | 1 | Sticky overrun |
| brk_chg | output | 1 | Break start or end seen |
| rx_active | output | 1 | Receiver enabled |

## Verification
The assertions assume that at most one of the enable, disable and reset commands is pulsed in any cycle. They also assume that the line-format configuration is changed only while no character is being assembled. The bench therefore issues commands one at a time and changes `cfg_len` and the parity settings only during idle line time after the queue has drained. Line transitions are driven on bit boundaries of 32 clocks, with `tick` every second clock. The mid-bit sample therefore sits well away from any edge, apart from the deliberately short false-start and glitch pulses.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DW    = 8;
    localparam int MIN_BITS = 5;

    typedef struct packed {
        logic             brk;
        logic             fe;
        logic             pe;
        logic [RX_DW-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_OFF,
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKW
    } rx_state_t;

    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       go_en,
    input  logic       go_off,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       char_vld,
    output rx_entry_t  char_ent,
    output logic       brk_start,
    output logic       brk_end,
    output logic       active
);
    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;

    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       bitn;
    logic [RX_DW-1:0] shreg;
    logic             par_bit;

    logic [3:0]       nbits;
    logic [RX_DW-1:0] data_al;
    logic             all_zero;
    logic             pe_calc;

    always_comb begin
        nbits    = char_bits(cfg_len);
        data_al  = shreg >> (4'(RX_DW) - nbits);
        all_zero = (shreg == '0) && !par_bit;
        pe_calc  = cfg_par_en & (^data_al ^ par_bit ^ cfg_par_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_OFF;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            char_vld  <= 1'b0;
            char_ent  <= '0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            char_vld  <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (go_off) begin
                state <= S_OFF;
                cnt   <= '0;
            end else if (go_en) begin
                state <= S_HUNT;
                cnt   <= '0;
            end else if (tick) begin
                case (state)
                    S_HUNT: begin
                        if (!rxd) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        // mid start bit, allowing for the synchroniser lag
                        if (cnt == CNT_W'(HALF - 2)) begin
                            cnt <= '0;
                            if (rxd) begin
                                state <= S_HUNT;
                            end else begin
                                state   <= S_DATA;
                                shreg   <= '0;
                                bitn    <= '0;
                                par_bit <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rxd, shreg[RX_DW-1:1]};
                            bitn  <= bitn + 4'd1;
                            if (bitn == nbits - 4'd1)
                                state <= cfg_par_en ? S_PAR : S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt     <= '0;
                            par_bit <= rxd;
                            state   <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt      <= '0;
                            char_vld <= 1'b1;
                            if (!rxd && all_zero) begin
                                char_ent  <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
                                brk_start <= 1'b1;
                                state     <= S_BRKW;
                            end else begin
                                char_ent <= '{brk: 1'b0, fe: !rxd, pe: pe_calc, data: data_al};
                                state    <= S_HUNT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRKW: begin
                        if (!rxd) begin
                            cnt <= '0;
                        end else if (cnt == CNT_W'(HALF - 1)) begin
                            cnt     <= '0;
                            brk_end <= 1'b1;
                            state   <= S_HUNT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign active = (state != S_OFF);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          wr_ok, rd_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= nxt(wptr);
            if (rd_ok) rptr <= nxt(rptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign dout  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxd,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cmd_rx_en,
    input  logic             cmd_rx_dis,
    input  logic             cmd_rx_reset,
    input  logic             cmd_clr_err,
    input  logic             cmd_clr_brk_chg,
    input  logic             rd_pop,
    output logic             rd_valid,
    output logic [RX_DW-1:0] rd_data,
    output logic             rd_brk,
    output logic             rd_fe,
    output logic             rd_pe,
    output logic             sts_brk,
    output logic             sts_fe,
    output logic             sts_pe,
    output logic             sts_ovr,
    output logic             brk_chg,
    output logic             rx_active
);
    logic      rxd_s;
    logic      char_vld, brk_start, brk_end;
    rx_entry_t char_ent, head;
    logic      fifo_empty, fifo_full;
    logic      push, clr_sts;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_rx_framer #(.OVS(OVS)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .rxd         (rxd_s),
        .go_en       (cmd_rx_en),
        .go_off      (cmd_rx_dis || cmd_rx_reset),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .char_vld    (char_vld),
        .char_ent    (char_ent),
        .brk_start   (brk_start),
        .brk_end     (brk_end),
        .active      (rx_active)
    );

    assign push = char_vld && !fifo_full;

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (cmd_rx_reset),
        .push  (push),
        .din   (char_ent),
        .pop   (rd_pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign clr_sts = cmd_clr_err || cmd_rx_reset;

    always_ff @(posedge clk) begin
        if (rst || clr_sts) begin
            sts_brk <= 1'b0;
            sts_fe  <= 1'b0;
            sts_pe  <= 1'b0;
            sts_ovr <= 1'b0;
        end else if (char_vld) begin
            if (char_ent.brk) sts_brk <= 1'b1;
            if (char_ent.fe)  sts_fe  <= 1'b1;
            if (char_ent.pe)  sts_pe  <= 1'b1;
            if (fifo_full)    sts_ovr <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_clr_brk_chg) brk_chg <= 1'b0;
        else if (brk_start || brk_end) brk_chg <= 1'b1;
    end

    assign rd_valid = !fifo_empty;
    assign rd_data  = head.data;
    assign rd_brk   = head.brk;
    assign rd_fe    = head.fe;
    assign rd_pe    = head.pe;
endmodule

// File: rtl/brk_uart_rx_chk.sv
module brk_uart_rx_chk (
    input logic clk,
    input logic rst,
    input logic cmd_rx_en,
    input logic cmd_rx_dis,
    input logic cmd_rx_reset,
    input logic cmd_clr_err,
    input logic cmd_clr_brk_chg,
    input logic rd_pop,
    input logic rd_valid,
    input logic sts_brk,
    input logic sts_fe,
    input logic sts_pe,
    input logic sts_ovr,
    input logic brk_chg,
    input logic rx_active,
    input logic char_vld,
    input logic fifo_full,
    input logic brk_start,
    input logic brk_end
);
    AST_BRKCHG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (brk_chg && !cmd_clr_brk_chg) |=> brk_chg); // R7

    AST_BRKCHG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_chg) |-> $past(brk_start || brk_end)); // R7

    AST_CLR_ERR: assert property (@(posedge clk) disable iff (rst)
        cmd_clr_err |=> !(sts_brk || sts_fe || sts_pe || sts_ovr)); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (char_vld && fifo_full && !cmd_clr_err && !cmd_rx_reset) |=> sts_ovr); // R9

    AST_FIFO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (char_vld && fifo_full && !rd_pop && !cmd_rx_reset) |=> fifo_full); // R9

    AST_RST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        cmd_rx_reset |=> (!rd_valid && !rx_active)); // R11

    AST_DIS_OFF: assert property (@(posedge clk) disable iff (rst)
        (cmd_rx_dis && !cmd_rx_en) |=> !rx_active); // R10

    AST_EN_ON: assert property (@(posedge clk) disable iff (rst)
        (cmd_rx_en && !cmd_rx_dis && !cmd_rx_reset) |=> rx_active); // R10
endmodule

bind brk_uart_rx brk_uart_rx_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_rx_en       (cmd_rx_en),
    .cmd_rx_dis      (cmd_rx_dis),
    .cmd_rx_reset    (cmd_rx_reset),
    .cmd_clr_err     (cmd_clr_err),
    .cmd_clr_brk_chg (cmd_clr_brk_chg),
    .rd_pop          (rd_pop),
    .rd_valid        (rd_valid),
    .sts_brk         (sts_brk),
    .sts_fe          (sts_fe),
    .sts_pe          (sts_pe),
    .sts_ovr         (sts_ovr),
    .brk_chg         (brk_chg),
    .rx_active       (rx_active),
    .char_vld        (char_vld),
    .fifo_full       (fifo_full),
    .brk_start       (brk_start),
    .brk_end         (brk_end)
);

// File: tb/brk_uart_rx_tb.sv
module brk_uart_rx_tb;
    import uart_rx_pkg::*;

    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cmd_rx_en = 1'b0, cmd_rx_dis = 1'b0, cmd_rx_reset = 1'b0;
    logic       cmd_clr_err = 1'b0, cmd_clr_brk_chg = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rd_valid, rd_brk, rd_fe, rd_pe;
    logic [7:0] rd_data;
    logic       sts_brk, sts_fe, sts_pe, sts_ovr, brk_chg, rx_active;

    int         checks = 0;
    int         fails = 0;
    int         mon_count = 0;
    logic       mon_en = 1'b1;
    string      cur_req = "R2";
    rx_entry_t  exp_q[$];

    brk_uart_rx u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis), .cmd_rx_reset(cmd_rx_reset),
        .cmd_clr_err(cmd_clr_err), .cmd_clr_brk_chg(cmd_clr_brk_chg),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_brk(rd_brk), .rd_fe(rd_fe), .rd_pe(rd_pe),
        .sts_brk(sts_brk), .sts_fe(sts_fe), .sts_pe(sts_pe), .sts_ovr(sts_ovr),
        .brk_chg(brk_chg), .rx_active(rx_active)
    );

    always #5 clk = ~clk;
    always @(posedge clk) tick <= ~tick;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops the head and compares it with the oldest expectation
    always @(negedge clk) begin
        rd_pop = 1'b0;
        if (!rst && mon_en && rd_valid) begin
            checks++;
            mon_count++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected entry actual %0h expected none",
                         cur_req, {rd_brk, rd_fe, rd_pe, rd_data});
            end else begin
                rx_entry_t e;
                e = exp_q.pop_front();
                if ({rd_brk, rd_fe, rd_pe, rd_data} !== e) begin
                    fails++;
                    $display("FAIL %s: entry actual %0h expected %0h",
                             cur_req, {rd_brk, rd_fe, rd_pe, rd_data}, e);
                end
            end
            rd_pop = 1'b1;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic cmd(input int k);
        @(negedge clk);
        case (k)
            0: cmd_rx_en = 1'b1;
            1: cmd_rx_dis = 1'b1;
            2: cmd_rx_reset = 1'b1;
            3: cmd_clr_err = 1'b1;
            default: cmd_clr_brk_chg = 1'b1;
        endcase
        @(negedge clk);
        {cmd_rx_en, cmd_rx_dis, cmd_rx_reset, cmd_clr_err, cmd_clr_brk_chg} = '0;
    endtask

    task automatic expect_ent(input logic brk, input logic fe, input logic pe, input logic [7:0] d);
        exp_q.push_back('{brk: brk, fe: fe, pe: pe, data: d});
    endtask

    // one frame plus one idle bit; the expectation is queued separately
    task automatic send(input logic [7:0] d, input int nb, input logic bad_par, input logic stop_hi);
        logic [7:0] dm;
        dm = d & 8'((1 << nb) - 1);
        drive(1'b0, BIT_CLKS);
        for (int i = 0; i < nb; i++) drive(d[i], BIT_CLKS);
        if (cfg_par_en) drive((^dm) ^ cfg_par_odd ^ bad_par, BIT_CLKS);
        if (stop_hi) drive(1'b1, BIT_CLKS);
        else begin
            drive(1'b0, 24);
            drive(1'b1, 8);
        end
        drive(1'b1, BIT_CLKS);
    endtask

    initial begin
        int base;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        // R1 reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 status", {sts_brk, sts_fe, sts_pe, sts_ovr, brk_chg}, 0);
        check("R1 rx_active", rx_active, 0);

        cmd(0);
        check("R10 enable", rx_active, 1);

        // R2 plain 8-bit frames
        cur_req = "R2";
        foreach (exp_q[i]) ;
        expect_ent(0, 0, 0, 8'hA5); send(8'hA5, 8, 0, 1);
        expect_ent(0, 0, 0, 8'h3C); send(8'h3C, 8, 0, 1);
        expect_ent(0, 0, 0, 8'hFF); send(8'hFF, 8, 0, 1);
        expect_ent(0, 0, 0, 8'h01); send(8'h01, 8, 0, 1);
        wait_clks(64);
        check("R2 drained", exp_q.size(), 0);

        // R3 short characters with parity
        cur_req = "R3";
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        expect_ent(0, 0, 0, 8'h15); send(8'hF5, 5, 0, 1);
        cfg_len = 2'd2; cfg_par_odd = 1'b1;
        expect_ent(0, 0, 0, 8'h5A); send(8'h5A, 7, 0, 1);
        wait_clks(64);
        check("R3 drained", exp_q.size(), 0);
        check("R3 no pe", sts_pe, 0);

        // R4 parity error, R8 clear
        cur_req = "R4";
        cfg_len = 2'd3; cfg_par_odd = 1'b0;
        expect_ent(0, 0, 1, 8'h07); send(8'h07, 8, 1, 1);
        wait_clks(64);
        check("R4 sts_pe", sts_pe, 1);
        check("R4 sts_fe", sts_fe, 0);
        cmd(3);
        check("R8 sts_pe cleared", sts_pe, 0);

        // R5 framing error (also a false start after the low stop bit)
        cur_req = "R5";
        cfg_par_en = 1'b0;
        expect_ent(0, 1, 0, 8'h80); send(8'h80, 8, 0, 0);
        wait_clks(64);
        check("R5 sts_fe", sts_fe, 1);
        check("R5 drained", exp_q.size(), 0);

        // R10 disable mid-character
        cur_req = "R10";
        base = mon_count;
        drive(1'b0, BIT_CLKS);
        drive(1'b1, BIT_CLKS); drive(1'b0, BIT_CLKS); drive(1'b1, BIT_CLKS);
        cmd(1);
        for (int i = 0; i < 5; i++) drive(1'b0, BIT_CLKS);
        drive(1'b1, 2 * BIT_CLKS);
        send(8'h77, 8, 0, 1);
        wait_clks(64);
        check("R10 rx_active", rx_active, 0);
        check("R10 nothing loaded", mon_count - base, 0);
        check("R10 status kept", {sts_fe, sts_pe, sts_brk, sts_ovr}, 4'b1000);
        cmd(0);
        expect_ent(0, 0, 0, 8'h5A); send(8'h5A, 8, 0, 1);
        wait_clks(64);
        check("R10 re-enabled", mon_count - base, 1);
        cmd(3);

        // R12 false start
        cur_req = "R12";
        base = mon_count;
        drive(1'b0, 8);
        drive(1'b1, 64);
        check("R12 no entry", mon_count - base, 0);
        expect_ent(0, 0, 0, 8'h3C); send(8'h3C, 8, 0, 1);
        wait_clks(64);
        check("R12 next frame", mon_count - base, 1);

        // R6 / R7 break
        cur_req = "R6";
        base = mon_count;
        expect_ent(1, 0, 0, 8'h00);
        drive(1'b0, 30 * BIT_CLKS);
        check("R6 one entry", mon_count - base, 1);
        check("R6 sts_brk", sts_brk, 1);
        check("R6 no fe", sts_fe, 0);
        check("R7 brk_chg at start", brk_chg, 1);
        cmd(3);
        check("R7 clr_err keeps brk_chg", brk_chg, 1);
        cmd(4);
        check("R7 brk_chg cleared", brk_chg, 0);
        drive(1'b1, 8);
        drive(1'b0, 128);
        check("R7 short high no end", brk_chg, 0);
        check("R6 still one entry", mon_count - base, 1);
        drive(1'b1, 64);
        check("R7 brk_chg at end", brk_chg, 1);
        cmd(4);

        // R13 break starting mid-character
        cur_req = "R13";
        base = mon_count;
        expect_ent(0, 1, 0, 8'h0B);
        expect_ent(1, 0, 0, 8'h00);
        drive(1'b0, BIT_CLKS);
        drive(1'b1, BIT_CLKS); drive(1'b1, BIT_CLKS);
        drive(1'b0, BIT_CLKS); drive(1'b1, BIT_CLKS);
        drive(1'b0, 25 * BIT_CLKS);
        drive(1'b1, 64);
        check("R13 two entries", mon_count - base, 2);
        check("R13 status", {sts_brk, sts_fe}, 2'b11);
        check("R13 brk_chg", brk_chg, 1);
        cmd(3);
        check("R8 all cleared", {sts_brk, sts_fe, sts_pe, sts_ovr}, 0);
        cmd(4);

        // R9 overrun
        cur_req = "R9";
        mon_en = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (i < 8) expect_ent(0, 0, 0, 8'(8'h10 + i));
            send(8'(8'h10 + i), 8, 0, 1);
        end
        wait_clks(64);
        check("R9 sts_ovr", sts_ovr, 1);
        check("R9 head kept", rd_data, 8'h10);
        mon_en = 1'b1;
        wait_clks(32);
        check("R9 eight kept", exp_q.size(), 0);
        check("R9 ovr sticky", sts_ovr, 1);
        cmd(3);

        // R11 receiver reset
        cur_req = "R11";
        mon_en = 1'b0;
        send(8'h42, 8, 0, 1);
        send(8'h81, 8, 0, 0);
        wait_clks(64);
        check("R11 pre valid", rd_valid, 1);
        check("R11 pre fe", sts_fe, 1);
        drive(1'b0, 30 * BIT_CLKS);
        drive(1'b1, 64);
        check("R11 pre brk_chg", brk_chg, 1);
        cmd(2);
        check("R11 flushed", rd_valid, 0);
        check("R11 status cleared", {sts_brk, sts_fe, sts_pe, sts_ovr}, 0);
        check("R11 off", rx_active, 0);
        check("R7 reset keeps brk_chg", brk_chg, 1);
        cmd(4);
        mon_en = 1'b1;
        cmd(0);
        expect_ent(0, 0, 0, 8'h66); send(8'h66, 8, 0, 1);
        wait_clks(64);
        check("R11 after reset", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule